// File: doc/BRIEF.md
# Vector operand overlap legality checker

This block sits in the decode stage of a vector unit. It takes one decoded vector instruction and the current element-width and group-size settings. It decides, in the same cycle, whether the instruction's register operands are well formed. For each vector register operand it works out the effective element width, the effective group multiplier and the span of registers the operand occupies. It flags any group that does not start on a multiple of its size. It flags any group whose size or width is beyond what the register file supports. It also flags the mixed-width overlaps that an implementation which restripes data internally cannot handle.

Three kinds of mixed-width overlap are caught. The first is two vector sources read at different widths from shared registers, as in an indexed store whose index and data groups collide. The second is a wide-plus-narrow arithmetic form whose two sources collide. The third is a destination written at one width over a source read at another. The result is a single illegal flag and a reason code, which the decoder uses to turn the instruction into an illegal-instruction trap. Delivering the trap happens elsewhere.

Top module: `vec_overlap_chk`

## Requirements
- R1: `illegal_o` is 1 exactly when `reason_o` is nonzero. The reason codes are: 0 legal, 1 misaligned group, 2 out of range, 3 mixed-width source overlap, 4 destination overlap. When several faults apply, the reported code follows this priority: 2 first, then 1, then 3, then 4.
- R2: Widths and group sizes use log2 encodings. For `sew_i` and `mem_eew_i`, 0=8, 1=16, 2=32 and 3=64 bits. For `lmul_i`, 0 to 3 give 1, 2, 4 and 8 registers. Each operand's group size is 2^(EEW−SEW+LMUL) in these encodings, and a size below one register counts as one.
- R2 (operand roles): The classes in `op_class_i` set each operand's role and width as follows.
  - 0 (vector-vector arithmetic): the vd field is the destination, at SEW, or at 2·SEW when `widen_i`=1. The vs2 and vs1 fields are sources at SEW.
  - 1 (wide-plus-narrow arithmetic): the vd field is the destination at 2·SEW. The vs2 field is a source at 2·SEW, and the vs1 field is a source at SEW.
  - 2 (unit load): the vd field is the destination at the memory EEW.
  - 3 (unit store): the vd field is the data source at the memory EEW.
  - 4 (indexed load): the vd field is the destination at SEW. The vs2 field is the index source at the memory EEW.
  - 5 (indexed store): the vd field is the data source at SEW. The vs2 field is the index source at the memory EEW.
- R3: An operand whose register number is not a multiple of its group size gives code 1.
- R4: An operand gives code 2 in any of these cases: its group size exceeds 8, its width exceeds 64 bits, or its group would reach past v31.
- R5: Two sources whose register spans intersect while their widths differ give code 3. Sources at equal widths may overlap, and may even be the very same register.
- R6: For indexed stores, the source overlap check depends on SEW. The same data and index registers are legal when the memory EEW equals SEW. They give code 3 when the two widths differ.
- R7: For class 1, any overlap of the vs1 group with the vs2 group gives code 3, whatever SEW is.
- R8: A destination whose span intersects a source of a different width gives code 4. A destination may overlap a source of equal width.
- R9: Fields that a class does not use have no effect on the result. This covers vs1 and vs2 in unit memory operations, vs1 in indexed ones, `mem_eew_i` in arithmetic classes, and `widen_i` outside class 0. Classes 6 and 7 have no vector operands and are never flagged.
- R10: The outputs are a combinational function of the current inputs, valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class_i | input | 3 | Instruction class code (R2) |
| widen_i | input | 1 | Doubles the destination width for class 0 |
| vd_i | input | 5 | Destination or store-data register number |
| vs2_i | input | 5 | Second source or index register number |
| vs1_i | input | 5 | First source register number |
| mem_eew_i | input | 2 | Static memory element width, log2 encoded |
| sew_i | input | 2 | Current element width, log2 encoded |
| lmul_i | input | 2 | Current group multiplier, log2 encoded |
| illegal_o | output | 1 | Instruction must trap as illegal |
| reason_o | output | 3 | Reason code for the fault (R1) |

## Verification
The assertions take the inputs to be settled, two-state values, and they assume that only integer group multipliers are encoded. Both are true of the 2-bit `lmul_i` field. The assertions make no assumption about which class or register combination appears. The stimulus is a list of directed instructions, each changed once per cycle after the rising edge and sampled at the falling edge. The list is chosen to hit every class, both widening forms, clamped and oversized group sizes, and each priority crossing between reason codes.

// File: rtl/vovl_pkg.sv
package vovl_pkg;
    localparam int REG_W    = 5;
    localparam int SPAN_W   = REG_W + 1;
    localparam int WID_W    = 2;
    localparam int EEW_W    = 3;
    localparam int NSLOT    = 3;
    localparam int MAX_GLOG = 3;
    localparam int MAX_ELOG = 3;
    localparam int CLS_W    = 3;
    localparam int RSN_W    = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU_VV = 3'd0,
        CLS_ALU_WV = 3'd1,
        CLS_LD_UNIT = 3'd2,
        CLS_ST_UNIT = 3'd3,
        CLS_LD_IDX = 3'd4,
        CLS_ST_IDX = 3'd5,
        CLS_NOVEC6 = 3'd6,
        CLS_NOVEC7 = 3'd7
    } op_cls_e;

    typedef enum logic [RSN_W-1:0] {
        RSN_NONE    = 3'd0,
        RSN_MISALGN = 3'd1,
        RSN_RANGE   = 3'd2,
        RSN_SRC_MIX = 3'd3,
        RSN_DST_OVL = 3'd4
    } reason_e;

    typedef struct packed {
        logic             used;
        logic             src;
        logic [EEW_W-1:0] eew;
    } slot_role_t;

    typedef struct packed {
        logic             illegal;
        logic [RSN_W-1:0] reason;
    } chk_res_t;
endpackage

// File: rtl/vovl_opnd.sv
module vovl_opnd
    import vovl_pkg::*;
(
    input  logic              used_i,
    input  logic [EEW_W-1:0]  eew_i,
    input  logic [WID_W-1:0]  sew_i,
    input  logic [WID_W-1:0]  lmul_i,
    input  logic [REG_W-1:0]  reg_i,
    output logic              range_bad_o,
    output logic              misal_o,
    output logic [SPAN_W-1:0] lo_o,
    output logic [SPAN_W-1:0] hi_o
);
    localparam int LOG_W = EEW_W + 1;

    logic signed [LOG_W-1:0] glog_s;
    logic [1:0]              glog;
    logic [SPAN_W-1:0]       size;
    logic                    size_bad;

    always_comb begin
        glog_s   = $signed({1'b0, eew_i}) - $signed({2'b00, sew_i})
                 + $signed({2'b00, lmul_i});
        size_bad = (eew_i > EEW_W'(MAX_ELOG)) || (glog_s > LOG_W'(MAX_GLOG));
        glog     = (glog_s < 0) ? 2'd0 : glog_s[1:0];
        size     = SPAN_W'(1) << glog;
        lo_o     = {1'b0, reg_i};
        hi_o     = lo_o + size - SPAN_W'(1);
        range_bad_o = used_i && (size_bad || (hi_o > SPAN_W'((1 << REG_W) - 1)));
        misal_o  = used_i && ((reg_i & REG_W'(size - SPAN_W'(1))) != '0);
    end
endmodule

// File: rtl/vovl_pair.sv
module vovl_pair
    import vovl_pkg::*;
(
    input  slot_role_t        a_i,
    input  logic [SPAN_W-1:0] a_lo_i,
    input  logic [SPAN_W-1:0] a_hi_i,
    input  slot_role_t        b_i,
    input  logic [SPAN_W-1:0] b_lo_i,
    input  logic [SPAN_W-1:0] b_hi_i,
    output logic              src_mix_o,
    output logic              dst_mix_o
);
    logic hit;

    always_comb begin
        hit = a_i.used && b_i.used && (a_i.eew != b_i.eew)
           && (a_lo_i <= b_hi_i) && (b_lo_i <= a_hi_i);
        src_mix_o = hit && a_i.src && b_i.src;
        dst_mix_o = hit && (a_i.src ^ b_i.src);
    end
endmodule

// File: rtl/vec_overlap_chk.sv
module vec_overlap_chk
    import vovl_pkg::*;
(
    input  logic [2:0] op_class_i,
    input  logic       widen_i,
    input  logic [4:0] vd_i,
    input  logic [4:0] vs2_i,
    input  logic [4:0] vs1_i,
    input  logic [1:0] mem_eew_i,
    input  logic [1:0] sew_i,
    input  logic [1:0] lmul_i,
    output logic       illegal_o,
    output logic [2:0] reason_o
);
    localparam int NPAIR = NSLOT * (NSLOT - 1) / 2;

    slot_role_t              role_d [NSLOT];
    logic [REG_W-1:0]        regs   [NSLOT];
    logic [SPAN_W-1:0]       lo     [NSLOT];
    logic [SPAN_W-1:0]       hi     [NSLOT];
    logic [NSLOT-1:0]        rng_bad;
    logic [NSLOT-1:0]        mis;
    logic [NPAIR-1:0]        src_mix;
    logic [NPAIR-1:0]        dst_mix;
    chk_res_t                res_d;

    logic [EEW_W-1:0] sew_x, wide_x, mem_x;

    // slot 0: vd field, slot 1: vs2 field, slot 2: vs1 field
    always_comb begin
        sew_x   = {1'b0, sew_i};
        wide_x  = sew_x + EEW_W'(1);
        mem_x   = {1'b0, mem_eew_i};
        regs[0] = vd_i;
        regs[1] = vs2_i;
        regs[2] = vs1_i;
        for (int s = 0; s < NSLOT; s++) role_d[s] = '0;
        unique case (op_cls_e'(op_class_i))
            CLS_ALU_VV: begin
                role_d[0] = '{used: 1'b1, src: 1'b0, eew: widen_i ? wide_x : sew_x};
                role_d[1] = '{used: 1'b1, src: 1'b1, eew: sew_x};
                role_d[2] = '{used: 1'b1, src: 1'b1, eew: sew_x};
            end
            CLS_ALU_WV: begin
                role_d[0] = '{used: 1'b1, src: 1'b0, eew: wide_x};
                role_d[1] = '{used: 1'b1, src: 1'b1, eew: wide_x};
                role_d[2] = '{used: 1'b1, src: 1'b1, eew: sew_x};
            end
            CLS_LD_UNIT: role_d[0] = '{used: 1'b1, src: 1'b0, eew: mem_x};
            CLS_ST_UNIT: role_d[0] = '{used: 1'b1, src: 1'b1, eew: mem_x};
            CLS_LD_IDX: begin
                role_d[0] = '{used: 1'b1, src: 1'b0, eew: sew_x};
                role_d[1] = '{used: 1'b1, src: 1'b1, eew: mem_x};
            end
            CLS_ST_IDX: begin
                role_d[0] = '{used: 1'b1, src: 1'b1, eew: sew_x};
                role_d[1] = '{used: 1'b1, src: 1'b1, eew: mem_x};
            end
            default: ;
        endcase
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        vovl_opnd u_opnd (
            .used_i      (role_d[s].used),
            .eew_i       (role_d[s].eew),
            .sew_i       (sew_i),
            .lmul_i      (lmul_i),
            .reg_i       (regs[s]),
            .range_bad_o (rng_bad[s]),
            .misal_o     (mis[s]),
            .lo_o        (lo[s]),
            .hi_o        (hi[s])
        );
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_pa
        for (genvar j = i + 1; j < NSLOT; j++) begin : g_pb
            localparam int P = i * (2 * NSLOT - i - 1) / 2 + (j - i - 1);
            vovl_pair u_pair (
                .a_i       (role_d[i]),
                .a_lo_i    (lo[i]),
                .a_hi_i    (hi[i]),
                .b_i       (role_d[j]),
                .b_lo_i    (lo[j]),
                .b_hi_i    (hi[j]),
                .src_mix_o (src_mix[P]),
                .dst_mix_o (dst_mix[P])
            );
        end
    end

    always_comb begin
        res_d.illegal = (|rng_bad) || (|mis) || (|src_mix) || (|dst_mix);
        if (|rng_bad)      res_d.reason = RSN_RANGE;
        else if (|mis)     res_d.reason = RSN_MISALGN;
        else if (|src_mix) res_d.reason = RSN_SRC_MIX;
        else if (|dst_mix) res_d.reason = RSN_DST_OVL;
        else               res_d.reason = RSN_NONE;
    end

    assign illegal_o = res_d.illegal;
    assign reason_o  = res_d.reason;
endmodule

// File: rtl/vovl_chk_sva.sv
module vovl_chk_sva (
    input logic [2:0] op_class_i,
    input logic       widen_i,
    input logic [1:0] lmul_i,
    input logic       illegal_o,
    input logic [2:0] reason_o
);
    always_comb begin
        a_r1_flag_code: assert (illegal_o == (reason_o != 3'd0));
        a_r1_code_set: assert (reason_o <= 3'd4);
        if (op_class_i >= 3'd2 && op_class_i != 3'd5)
            a_r5_single_src_no_mix: assert (reason_o != 3'd3);
        if (reason_o == 3'd4)
            a_r8_dst_needs_mixed: assert ((op_class_i == 3'd0 && widen_i)
                                         || op_class_i == 3'd1 || op_class_i == 3'd4);
        if (op_class_i >= 3'd6)
            a_r9_novec_legal: assert (!illegal_o);
        if (op_class_i == 3'd0 && !widen_i && lmul_i == 2'd0)
            a_r3_single_reg_legal: assert (!illegal_o);
    end
endmodule

bind vec_overlap_chk vovl_chk_sva u_sva (
    .op_class_i (op_class_i),
    .widen_i    (widen_i),
    .lmul_i     (lmul_i),
    .illegal_o  (illegal_o),
    .reason_o   (reason_o)
);

// File: tb/vec_overlap_chk_tb.sv
module vec_overlap_chk_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_class;
    logic       widen;
    logic [4:0] vd, vs2, vs1;
    logic [1:0] mem_eew, sew, lmul;
    logic       illegal;
    logic [2:0] reason;

    typedef struct {
        logic       illegal;
        logic [2:0] reason;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_overlap_chk u_dut (
        .op_class_i (op_class),
        .widen_i    (widen),
        .vd_i       (vd),
        .vs2_i      (vs2),
        .vs1_i      (vs1),
        .mem_eew_i  (mem_eew),
        .sew_i      (sew),
        .lmul_i     (lmul),
        .illegal_o  (illegal),
        .reason_o   (reason)
    );

    task automatic run(input logic [2:0] c, input logic w, input logic [4:0] d,
                       input logic [4:0] s2, input logic [4:0] s1, input logic [1:0] e,
                       input logic [1:0] sw, input logic [1:0] lm,
                       input logic [2:0] rsn, input string tag);
        exp_t x;
        @(posedge clk);
        #1;
        op_class = c; widen = w; vd = d; vs2 = s2; vs1 = s1;
        mem_eew = e; sew = sw; lmul = lm;
        x.illegal = (rsn != 3'd0);
        x.reason  = rsn;
        x.tag     = tag;
        exp_q.push_back(x);
    endtask

    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t x;
            x = exp_q.pop_front();
            checks++;
            if (illegal !== x.illegal || reason !== x.reason) begin
                failures++;
                $display("FAIL %s illegal=%0d reason=%0d expected illegal=%0d reason=%0d",
                         x.tag, illegal, reason, x.illegal, x.reason);
            end
        end
    end

    initial begin
        op_class = 3'd0; widen = 1'b0; vd = '0; vs2 = '0; vs1 = '0;
        mem_eew = '0; sew = '0; lmul = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // classes: 0 vv, 1 wv, 2 ld, 3 st, 4 ldx, 5 stx
        run(0,0, 0, 0, 0,0,0,0, 0, "R1 reset-state inputs, same reg same width");
        run(0,0, 4, 8,12,0,0,2, 0, "R2 vv lmul4 aligned");
        run(0,0, 4, 6,12,0,0,2, 1, "R3 vv vs2 misaligned");
        run(0,0, 8,16,25,0,0,3, 2, "R4 vs1 group past v31");
        run(0,0, 8,16,20,0,0,3, 1, "R3 vs1 misaligned lmul8");
        run(0,1, 0, 8,16,0,0,3, 2, "R4 widened dest group 16");
        run(0,1, 0, 1, 2,0,3,0, 2, "R4 widened width over 64");
        run(0,1, 0, 4, 6,0,0,1, 0, "R8 widen vv disjoint");
        run(0,1, 0, 2, 6,0,0,1, 4, "R8 widen dest over narrow src");
        run(1,0, 2, 2, 4,0,1,0, 0, "R8 wv dest equals wide src");
        run(1,0, 2, 4, 5,0,1,0, 3, "R7 wv wide narrow overlap sew16");
        run(1,0, 2, 4, 5,0,0,0, 3, "R7 wv wide narrow overlap sew8");
        run(1,0, 4, 4, 4,0,1,0, 3, "R1 src mix outranks dest overlap");
        run(5,0, 8, 9, 0,0,2,2, 3, "R6 stx index inside data group");
        run(5,0, 8, 8, 0,0,0,2, 0, "R6 stx same reg same width");
        run(5,0, 8, 8, 0,2,0,2, 2, "R4 stx index group 16");
        run(5,0, 7, 7, 0,0,3,0, 3, "R2 clamped index group same reg");
        run(2,0, 8, 0, 0,3,0,1, 2, "R4 unit load group 16");
        run(2,0, 8, 0, 0,2,0,1, 0, "R2 unit load group 8 aligned");
        run(2,0, 4, 0, 0,2,0,1, 1, "R3 unit load group 8 misaligned");
        run(2,0, 4, 5, 3,0,0,2, 0, "R9 unit load ignores vs1 vs2");
        run(4,0, 4, 4, 0,1,0,1, 4, "R8 ldx dest over index");
        run(4,0, 4, 8, 3,1,0,1, 0, "R8 ldx disjoint, R9 vs1 ignored");
        run(3,0, 3, 0, 0,1,0,0, 1, "R3 unit store misaligned");
        run(5,1, 8, 8, 0,0,0,2, 0, "R9 widen ignored for stx");
        run(6,1, 3, 5, 7,3,3,3, 0, "R9 class 6 never flagged");
        run(7,0,31,29,27,2,0,3, 0, "R9 class 7 never flagged");
        run(0,0, 4, 8,12,3,0,2, 0, "R9 mem eew ignored for vv");
        run(0,1, 0, 8,17,0,0,3, 2, "R1 range outranks misaligned");
        run(0,0, 2, 4, 6,0,0,1, 0, "R10 result in same cycle");
        wait (exp_q.size() == 0);
        @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule